// File: doc/BRIEF.md
# Streaming Global Max-Pool Aggregator

This block keeps one running global feature vector of `VEC_LEN` signed fixed-point elements. It folds in a stream of per-point local feature vectors. A start pulse opens a run and empties the vector, so every element reads as zero. Each local vector then arrives as `VEC_LEN/LANES` beats of `LANES` elements. Every element of the stored vector is replaced by the signed maximum of its stored value and the matching incoming value.

The number of points in a run has no limit. Storage is a single vector whatever the point count, because each point is merged as it arrives and never kept.

A run closes in one of two ways. The first is a last flag on the final beat of a local vector. The second is an end pulse, which also covers a run with no points. The block then refuses further input and streams the finished vector out beat by beat under a valid/ready handshake. After the final beat it waits idle for the next start pulse.

Top module: `fmax_top`

## Requirements
- R1: While reset is held and on the first edge after reset is released, `inReady` and `outValid` are both low.
- R2: A `runStart` pulse outside readout makes every stored element read as zero. A run with no points therefore reads back all zeros.
- R3: The update is a signed two's-complement maximum against a zero start. Every element read back is at least zero and equals the largest value seen for that element in the run. This includes the extremes 0x7FFFFFFF and 0x80000000.
- R4: Beat k of a local vector (k = 0 to VEC_LEN/LANES-1) carries elements k*LANES+j for j = 0 to LANES-1. Element k*LANES+j sits at `inData[j*ELEM_W +: ELEM_W]`, and the same packing is used on `outData`.
- R5: `inLast` is sampled only on an accepted beat with k = VEC_LEN/LANES-1, and readout begins on the next cycle. On any other beat it has no effect.
- R6: A `runEnd` pulse while accumulating, with `runStart` low, starts readout on the next cycle. Beats already accepted stay merged. `runStart` takes priority over `runEnd`.
- R7: During readout `inReady` is low, and `runStart`, `runEnd` and `inValid` have no effect on the data read out.
- R8: Readout presents beats k = 0 upward with `outEnd` high only on the final beat. While `outReady` is low, `outData` and `outEnd` hold.
- R9: After the final readout beat is taken, `inReady` and `outValid` stay low until the next `runStart`. `inReady` is also low in any cycle where `runStart` or `runEnd` is high.
- R10: A run of many local vectors yields the elementwise maximum over all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runStart | input | 1 | Open a run and zero the global vector |
| runEnd | input | 1 | Close the run and begin readout |
| inValid | input | 1 | Local feature beat valid |
| inReady | output | 1 | Local feature beat accepted when high with inValid |
| inData | input | LANES*ELEM_W | LANES signed elements of a local vector |
| inLast | input | 1 | Marks the final local vector of the run |
| outValid | output | 1 | Readout beat valid |
| outReady | input | 1 | Consumer takes the readout beat |
| outData | output | LANES*ELEM_W | LANES elements of the global vector |
| outEnd | output | 1 | Final readout beat |

## Verification
Several behaviours hold on every cycle, and the assertions check them there:
- `inReady` stays low during readout.
- Output beats hold while stalled.
- No element read out is ever negative.
- The block goes idle after the final beat.
- Start and end pulses move the block into accumulation and readout.

Other behaviours only show in the bench's scenarios, which compare each cycle against a behavioural model:
- The exact maxima over many points.
- The lane and beat ordering.
- The extremes of the signed compare.
- An early last flag being ignored.
- Pokes during readout leaving the data unchanged.

// File: rtl/fmax_pkg.sv
package fmax_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_READ = 2'd2
  } aggState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic wrEn;
  } aggStrobe_t;

endpackage

// File: rtl/fmax_ctrl.sv
module fmax_ctrl
  import fmax_pkg::*;
#(
  parameter int ROWS      = 512,
  parameter int ROW_IDX_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 runStart,
  input  logic                 runEnd,
  input  logic                 inValid,
  input  logic                 inLast,
  input  logic                 outReady,
  output logic                 inReady,
  output logic                 outValid,
  output logic                 outEnd,
  output aggStrobe_t           strobes,
  output logic [ROW_IDX_W-1:0] wrRow,
  output logic [ROW_IDX_W-1:0] rdRow,
  output aggState_t            stateQ
);

  localparam logic [ROW_IDX_W-1:0] LAST_ROW = ROW_IDX_W'(ROWS - 1);

  aggState_t stateD;
  logic [ROW_IDX_W-1:0] beatQ, beatD, rdQ, rdD;
  logic startOk, endOk, beatFire, outFire;

  always_comb begin
    startOk  = runStart && (stateQ != ST_READ);
    endOk    = runEnd && !runStart && (stateQ == ST_ACC);
    inReady  = (stateQ == ST_ACC) && !runStart && !runEnd;
    beatFire = inValid && inReady;
    outValid = (stateQ == ST_READ);
    outFire  = outValid && outReady;
    outEnd   = outValid && (rdQ == LAST_ROW);

    strobes.clearAll = startOk;
    strobes.wrEn     = beatFire;
    wrRow            = beatQ;
    rdRow            = rdQ;

    stateD = stateQ;
    beatD  = beatQ;
    rdD    = rdQ;

    if (startOk) begin
      stateD = ST_ACC;
      beatD  = '0;
    end else if (endOk) begin
      stateD = ST_READ;
      rdD    = '0;
    end else if (beatFire) begin
      if (beatQ == LAST_ROW) begin
        beatD = '0;
        if (inLast) begin
          stateD = ST_READ;
          rdD    = '0;
        end
      end else begin
        beatD = beatQ + 1'b1;
      end
    end else if (outFire) begin
      if (rdQ == LAST_ROW) begin
        stateD = ST_IDLE;
      end else begin
        rdD = rdQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      beatQ  <= '0;
      rdQ    <= '0;
    end else begin
      stateQ <= stateD;
      beatQ  <= beatD;
      rdQ    <= rdD;
    end
  end

endmodule

// File: rtl/fmax_datapath.sv
module fmax_datapath
  import fmax_pkg::*;
#(
  parameter int ELEM_W    = 32,
  parameter int LANES     = 2,
  parameter int ROWS      = 512,
  parameter int ROW_IDX_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  aggStrobe_t                strobes,
  input  logic [ROW_IDX_W-1:0]      wrRow,
  input  logic [ROW_IDX_W-1:0]      rdRow,
  input  logic [LANES*ELEM_W-1:0]   inData,
  output logic [LANES*ELEM_W-1:0]   rdData
);

  localparam int ROW_W = LANES * ELEM_W;

  logic [ROW_W-1:0] rowMem [ROWS];
  // set bit: row holds no merged point yet, reads as zero
  logic [ROWS-1:0]  freshQ;
  logic [ROW_W-1:0] curRow, nextRow;

  assign curRow = freshQ[wrRow] ? '0 : rowMem[wrRow];
  assign rdData = freshQ[rdRow] ? '0 : rowMem[rdRow];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [ELEM_W-1:0] oldV, newV;
    assign oldV = curRow[g*ELEM_W +: ELEM_W];
    assign newV = inData[g*ELEM_W +: ELEM_W];
    assign nextRow[g*ELEM_W +: ELEM_W] = (newV > oldV) ? newV : oldV;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      rowMem[wrRow] <= nextRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      freshQ <= '1;
    end else if (strobes.wrEn) begin
      freshQ[wrRow] <= 1'b0;
    end
  end

endmodule

// File: rtl/fmax_top.sv
module fmax_top
  import fmax_pkg::*;
#(
  parameter int ELEM_W  = 32,
  parameter int VEC_LEN = 1024,
  parameter int LANES   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    runStart,
  input  logic                    runEnd,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES*ELEM_W-1:0] inData,
  input  logic                    inLast,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES*ELEM_W-1:0] outData,
  output logic                    outEnd
);

  localparam int ROWS      = VEC_LEN / LANES;
  localparam int ROW_IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  aggStrobe_t           strobes;
  aggState_t            stateQ;
  logic [ROW_IDX_W-1:0] wrRow, rdRow;

  fmax_ctrl #(
    .ROWS(ROWS), .ROW_IDX_W(ROW_IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .runStart(runStart), .runEnd(runEnd),
    .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outEnd(outEnd),
    .strobes(strobes), .wrRow(wrRow), .rdRow(rdRow), .stateQ(stateQ)
  );

  fmax_datapath #(
    .ELEM_W(ELEM_W), .LANES(LANES), .ROWS(ROWS), .ROW_IDX_W(ROW_IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrRow(wrRow),
    .rdRow(rdRow), .inData(inData), .rdData(outData)
  );

endmodule

// File: rtl/fmax_checker.sv
module fmax_checker
  import fmax_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    runStart,
  input logic                    runEnd,
  input logic                    inReady,
  input logic                    outValid,
  input logic                    outReady,
  input logic [LANES*ELEM_W-1:0] outData,
  input logic                    outEnd,
  input aggState_t               stateQ
);

  function automatic logic anyNegative(input logic [LANES*ELEM_W-1:0] v);
    logic r;
    r = 1'b0;
    for (int j = 0; j < LANES; j++) r = r | v[j*ELEM_W + ELEM_W - 1];
    return r;
  endfunction

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!inReady && !outValid));

  a_r2_start_opens_run: assert property (@(posedge clk) disable iff (!rst_n)
    (runStart && stateQ != ST_READ) |=> (stateQ == ST_ACC && !outValid));

  a_r3_never_negative: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !anyNegative(outData));

  a_r6_end_starts_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (runEnd && !runStart && stateQ == ST_ACC) |=> outValid);

  a_r7_no_ready_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outEnd)));

  a_r9_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outEnd) |=> (!outValid && !inReady));

endmodule

bind fmax_top fmax_checker #(.ELEM_W(ELEM_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .runStart(runStart), .runEnd(runEnd),
  .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outEnd(outEnd), .stateQ(stateQ)
);

// File: tb/fmax_top_test.sv
`timescale 1ns/1ps
module fmax_top_test;

  localparam int EW   = 32;
  localparam int D    = 1024;
  localparam int P    = 2;
  localparam int ROWS = D / P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runStart = 1'b0, runEnd = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic outReady = 1'b0;
  logic [P*EW-1:0] inData = '0;
  logic inReady, outValid, outEnd;
  logic [P*EW-1:0] outData;

  always #4 clk = ~clk;

  fmax_top #(.ELEM_W(EW), .VEC_LEN(D), .LANES(P)) uut (
    .clk(clk), .rst_n(rst_n), .runStart(runStart), .runEnd(runEnd),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outEnd(outEnd)
  );

  // behavioural model: 0 idle, 1 accumulating, 2 reading out
  int mode = 0, beat = 0, rd = 0;
  logic signed [EW-1:0] refVec [D];
  int errors = 0, checks = 0;
  string curTag = "R1";
  bit accepted;

  task automatic check(input string what, input logic [P*EW-1:0] act, input logic [P*EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", curTag, what, act, exp);
    end
  endtask

  task automatic step();
    logic expReady, expValid, expEnd;
    logic [P*EW-1:0] expData;
    #1;
    expReady = (mode == 1) && !runStart && !runEnd;
    expValid = (mode == 2);
    expEnd   = (mode == 2) && (rd == ROWS - 1);
    check("inReady", P*EW'(inReady), P*EW'(expReady));
    check("outValid", P*EW'(outValid), P*EW'(expValid));
    if (expValid) begin
      for (int j = 0; j < P; j++) expData[j*EW +: EW] = refVec[rd*P + j];
      check("outData", outData, expData);
      check("outEnd", P*EW'(outEnd), P*EW'(expEnd));
    end
    accepted = inValid && expReady;
    @(posedge clk);
    if (!rst_n) begin
      mode = 0; beat = 0; rd = 0;
    end else if (mode != 2) begin
      if (runStart) begin
        for (int i = 0; i < D; i++) refVec[i] = '0;
        mode = 1; beat = 0;
      end else if (mode == 1 && runEnd) begin
        mode = 2; rd = 0;
      end else if (mode == 1 && inValid) begin
        for (int j = 0; j < P; j++)
          if ($signed(inData[j*EW +: EW]) > refVec[beat*P + j])
            refVec[beat*P + j] = inData[j*EW +: EW];
        if (beat == ROWS - 1) begin
          beat = 0;
          if (inLast) begin mode = 2; rd = 0; end
        end else beat++;
      end
    end else if (outReady) begin
      if (rd == ROWS - 1) mode = 0; else rd++;
    end
    @(negedge clk);
  endtask

  task automatic pulseStart();
    runStart = 1'b1; step(); runStart = 1'b0;
  endtask

  // kind 0 random, 1 signed extremes; lastBeat: -1 none, else beat carrying inLast
  task automatic sendVector(input int kind, input int lastBeat);
    for (int b = 0; b < ROWS; b++) begin
      if ($urandom_range(0, 7) == 0) begin
        inValid = 1'b0; step();
      end
      for (int j = 0; j < P; j++) begin
        case (kind)
          1: case ((b + j) % 4)
               0: inData[j*EW +: EW] = 32'h7FFFFFFF;
               1: inData[j*EW +: EW] = 32'h80000000;
               2: inData[j*EW +: EW] = 32'hFFFFFFFF;
               default: inData[j*EW +: EW] = 32'h00000001;
             endcase
          default: inData[j*EW +: EW] = $urandom();
        endcase
      end
      inLast  = (b == lastBeat);
      inValid = 1'b1;
      step();
    end
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic drain(input int stallPct, input bit poke);
    int guard = 0;
    while (mode == 2 && guard < 4 * ROWS) begin
      outReady = ($urandom_range(0, 99) >= stallPct);
      if (poke) begin
        inValid  = $urandom_range(0, 1);
        inData   = {P{32'h7FFFFFFF}};
        runStart = ($urandom_range(0, 9) == 0);
        runEnd   = ($urandom_range(0, 9) == 0);
      end
      step();
      guard++;
    end
    outReady = 1'b0; inValid = 1'b0; runStart = 1'b0; runEnd = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with input pokes that must not matter
    curTag = "R1";
    inValid = 1'b1;
    repeat (3) step();
    inValid = 1'b0;
    rst_n = 1'b1;
    step();

    // R2 / R6: zero-point run reads back zeros
    curTag = "R2";
    pulseStart();
    curTag = "R6";
    runEnd = 1'b1; step(); runEnd = 1'b0;
    curTag = "R2";
    drain(0, 1'b0);

    // R4 / R8: random lanes, stalled readout
    curTag = "R4";
    pulseStart();
    sendVector(0, -1);
    sendVector(0, -1);
    sendVector(0, ROWS - 1);
    curTag = "R8";
    drain(40, 1'b0);

    // R9: idle after readout, inputs refused until start
    curTag = "R9";
    inValid = 1'b1; runEnd = 1'b1;
    repeat (4) step();
    inValid = 1'b0; runEnd = 1'b0;

    // R3: signed extremes against zero start
    curTag = "R3";
    pulseStart();
    sendVector(1, ROWS - 1);
    drain(0, 1'b0);

    // R5: inLast on a non-final beat is ignored
    curTag = "R5";
    pulseStart();
    sendVector(0, 0);
    sendVector(0, 3);
    sendVector(0, ROWS - 1);
    // R7: start, end and input pokes during readout change nothing
    curTag = "R7";
    drain(20, 1'b1);

    // R10: many points accumulate; end pulse mid-run keeps merged beats (R6)
    curTag = "R10";
    pulseStart();
    for (int n = 0; n < 8; n++) sendVector(0, -1);
    curTag = "R6";
    runEnd = 1'b1; step(); runEnd = 1'b0;
    curTag = "R10";
    drain(10, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule